// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This block watches 24 external interrupt pins and turns activity on them into requests for a main interrupt controller. Each pin is brought into the clock domain by a two-stage synchroniser. A third flop holds the previous synchronised sample so that edges can be seen. A per-line 3-bit trigger field picks one of five conditions: low level, high level, falling edge, rising edge or any edge. A line takes part only while its 2-bit pin-function field selects the interrupt function.

Lines 0 to 3 are not latched here. Each drives its own registered request straight to the main controller. Lines 4 to 23 latch a pending bit, which software clears by writing ones. A mask then gates each pending bit into one of two shared requests: one for lines 4 to 7 and one for lines 8 to 23. A separate wake request collects the pending lines 4 to 15 that are not wake-masked. Software uses an eight-word register port with a single-cycle write strobe and a combinational read.

Top module: `xirq_trigger_unit`

## Requirements
- R1: After reset these registers read as follows: all trigger and function registers read 0, the mask register reads 0x00FFFFF0, the pending register reads 0 and the wake-mask register reads 0x0000FFF0. All request outputs are low.
- R2: A line responds only while its 2-bit function field equals 2'b10. Line k uses bits [2k+1:2k] of word 3 for lines 0–15, and bits [2(k-16)+1:2(k-16)] of word 4 for lines 16–23. With any other value the line never sets pending and never raises a request.
- R3: The trigger field of line k is bits [4j+2:4j] of word k/8, where j = k mod 8. The codes are: 000 low level, 001 high level, 01x falling edge, 10x rising edge, 11x either edge.
- R4: In an edge mode, one qualifying pin transition sets the line's pending bit. The bit becomes visible after the third rising clock edge that follows the pin change. A transition of the other polarity has no effect.
- R5: In a level mode, clearing a pending bit while the level is still active makes it read 0 for exactly one cycle, and it sets again on the next edge. Once the level is gone, a clear leaves the bit at 0.
- R6: Word 6 holds the pending bits of lines 4–23 at their line positions. Writing 1 to a bit clears it and writing 0 leaves it unchanged. An edge event that lands in the same cycle as its clear is kept.
- R7: The mask register is word 5, with bit k for line k (4–23), and 1 means blocked. The low-group request is the OR of unmasked pending lines 4–7. The high-group request is the same for lines 8–23. A masked line still latches pending. The low-group request is low whenever all four of its mask bits are 1.
- R8: Lines 0–3 have no pending bit. Pending bits 3:0 read as 0. Request output bit i is a registered copy of line i's trigger condition. In an edge mode it pulses for one cycle; in a level mode it stays high while the level is held.
- R9: The wake-mask register is word 7, with bit k for line k. The wake request is high when some line from 4 to 15 is pending with its wake-mask bit at 0. Lines 16–23 never raise a wake.
- R10: Unimplemented bits read as 0. In words 5 and 6 these are bits 31:24 and 3:0. In word 7 they are every bit outside 15:4. In word 4 they are bits 31:16. In words 0–2 they are the top bit of each 4-bit slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 24 | Asynchronous external interrupt pins |
| cfg_we | input | 1 | Register write strobe, one write per cycle |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_addr |
| direct_req | output | 4 | Per-line requests for lines 0–3 |
| grp_lo_req | output | 1 | Shared request for lines 4–7 |
| grp_hi_req | output | 1 | Shared request for lines 8–23 |
| wake_req | output | 1 | Wake request from lines 4–15 |

## Verification
A pin change reaches the pending bits and the direct requests after the third rising edge: two synchroniser stages, then the latch or request register. The group and wake outputs follow the state combinationally, so they are due in that same cycle. A register write takes effect on the edge that samples the strobe. In a level mode, a cleared bit re-sets exactly one edge later. The bench changes pins and strobes on the falling edge and counts falling edges to reach each due point. It reads the one-cycle gap after a level clear just after the clearing rising edge.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int NLINES       = 24;
    localparam int DIRECT_N     = 4;
    localparam int GA_LO        = 4;
    localparam int GA_HI        = 7;
    localparam int GB_LO        = 8;
    localparam int GB_HI        = NLINES - 1;
    localparam int WAKE_LO      = 4;
    localparam int WAKE_HI      = 15;
    localparam int DW           = 32;
    localparam int AW           = 3;
    localparam int MODE_W       = 3;
    localparam int TRIG_STRIDE  = 4;
    localparam int TRIG_PER_REG = DW / TRIG_STRIDE;
    localparam int TRIG_REGS    = NLINES / TRIG_PER_REG;
    localparam int FUNC_W       = 2;
    localparam int FUNC_PER_REG = DW / FUNC_W;
    localparam int FUNC_REGS    = (NLINES + FUNC_PER_REG - 1) / FUNC_PER_REG;

    localparam logic [FUNC_W-1:0] FUNC_IRQ = 2'b10;

    function automatic logic [NLINES-1:0] span(input int lo, input int hi);
        logic [NLINES-1:0] m;
        m = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [NLINES-1:0] LATCH_LINES = span(DIRECT_N, NLINES - 1);
    localparam logic [NLINES-1:0] GRP_A_SET   = span(GA_LO, GA_HI);
    localparam logic [NLINES-1:0] GRP_B_SET   = span(GB_LO, GB_HI);
    localparam logic [NLINES-1:0] WAKE_ALLOW  = span(WAKE_LO, WAKE_HI);

    function automatic logic [DW-1:0] trig_wmask();
        logic [DW-1:0] m;
        m = '0;
        for (int j = 0; j < TRIG_PER_REG; j++) begin
            for (int b = 0; b < MODE_W; b++) m[j*TRIG_STRIDE + b] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [DW-1:0] func_wmask(input int r);
        logic [DW-1:0] m;
        m = '0;
        for (int j = 0; j < FUNC_PER_REG; j++) begin
            if (r * FUNC_PER_REG + j < NLINES) begin
                for (int b = 0; b < FUNC_W; b++) m[j*FUNC_W + b] = 1'b1;
            end
        end
        return m;
    endfunction

    typedef enum logic [AW-1:0] {
        RS_TRIG0   = 3'd0,
        RS_TRIG1   = 3'd1,
        RS_TRIG2   = 3'd2,
        RS_FUNC_LO = 3'd3,
        RS_FUNC_HI = 3'd4,
        RS_MASK    = 3'd5,
        RS_PEND    = 3'd6,
        RS_WAKE    = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } samp_t;

    function automatic logic trig_hit(input logic [MODE_W-1:0] m, input samp_t s);
        logic r;
        case (m[2:1])
            2'b00:   r = m[0] ? s.cur : ~s.cur;
            2'b01:   r = s.prev & ~s.cur;
            2'b10:   r = s.cur & ~s.prev;
            default: r = s.cur ^ s.prev;
        endcase
        return r;
    endfunction

    function automatic logic is_level(input logic [MODE_W-1:0] m);
        return m[2:1] == 2'b00;
    endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync
    import xirq_pkg::*;
#(
    parameter int LINES = NLINES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LINES-1:0]     pin_raw,
    output samp_t [LINES-1:0]    smp
);

    logic [LINES-1:0] stage1_q;
    logic [LINES-1:0] stage2_q;
    logic [LINES-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
            prev_q   <= '0;
        end else begin
            stage1_q <= pin_raw;
            stage2_q <= stage1_q;
            prev_q   <= stage2_q;
        end
    end

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign smp[i].cur  = stage2_q[i];
        assign smp[i].prev = prev_q[i];
    end

endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
    import xirq_pkg::*;
#(
    parameter int LINES = NLINES
) (
    input  samp_t [LINES-1:0]             smp,
    input  logic  [LINES-1:0][MODE_W-1:0] mode,
    input  logic  [LINES-1:0]             en,
    output logic  [LINES-1:0]             hit
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign hit[i] = en[i] & trig_hit(mode[i], smp[i]);
    end

endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
    import xirq_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [AW-1:0]                 addr,
    input  logic [DW-1:0]                 wdata,
    input  logic [NLINES-1:0]             hit,
    output logic [DW-1:0]                 rdata,
    output logic [NLINES-1:0][MODE_W-1:0] mode,
    output logic [NLINES-1:0]             en_vec,
    output logic [NLINES-1:0]             mask_q,
    output logic [NLINES-1:0]             pend_q,
    output logic [NLINES-1:0]             wmask_q
);

    localparam logic [DW-1:0] TRIG_WMASK = trig_wmask();

    logic [TRIG_REGS-1:0][DW-1:0] trig_q;
    logic [FUNC_REGS-1:0][DW-1:0] func_q;
    logic [NLINES-1:0]            lvl_vec;
    logic [NLINES-1:0]            clr_vec;
    logic [NLINES-1:0]            pend_d;
    reg_sel_e                     sel;

    assign sel = reg_sel_e'(addr);

    // Per-line field extraction from the packed configuration words
    for (genvar k = 0; k < NLINES; k++) begin : g_field
        assign mode[k]    = trig_q[k / TRIG_PER_REG][TRIG_STRIDE * (k % TRIG_PER_REG) +: MODE_W];
        assign en_vec[k]  = func_q[k / FUNC_PER_REG][FUNC_W * (k % FUNC_PER_REG) +: FUNC_W] == FUNC_IRQ;
        assign lvl_vec[k] = is_level(mode[k]);
    end

    // Write-one-to-clear; a level clear suppresses that cycle's re-set,
    // an edge event in the clear cycle survives.
    assign clr_vec = (we && sel == RS_PEND) ? (wdata[NLINES-1:0] & LATCH_LINES) : '0;
    assign pend_d  = ((pend_q & ~clr_vec) | (hit & ~(clr_vec & lvl_vec))) & LATCH_LINES;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q  <= '0;
            func_q  <= '0;
            mask_q  <= LATCH_LINES;
            wmask_q <= WAKE_ALLOW;
            pend_q  <= '0;
        end else begin
            pend_q <= pend_d;
            if (we) begin
                for (int t = 0; t < TRIG_REGS; t++) begin
                    if (int'(sel) == t) trig_q[t] <= wdata & TRIG_WMASK;
                end
                for (int f = 0; f < FUNC_REGS; f++) begin
                    if (int'(sel) == int'(RS_FUNC_LO) + f) func_q[f] <= wdata & func_wmask(f);
                end
                if (sel == RS_MASK) mask_q  <= wdata[NLINES-1:0] & LATCH_LINES;
                if (sel == RS_WAKE) wmask_q <= wdata[NLINES-1:0] & WAKE_ALLOW;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            RS_TRIG0:   rdata = trig_q[0];
            RS_TRIG1:   rdata = trig_q[1];
            RS_TRIG2:   rdata = trig_q[2];
            RS_FUNC_LO: rdata = func_q[0];
            RS_FUNC_HI: rdata = func_q[1];
            RS_MASK:    rdata = DW'(mask_q);
            RS_PEND:    rdata = DW'(pend_q);
            RS_WAKE:    rdata = DW'(wmask_q);
            default:    rdata = '0;
        endcase
    end

    // R1: state right after reset
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pend_q == '0 && mask_q == LATCH_LINES && wmask_q == WAKE_ALLOW));

    // R6: a pending bit only falls through a write-one clear
    a_r6_no_silent_fall: assert property (@(posedge clk) disable iff (rst)
        (($past(pend_q) & ~pend_q & ~$past(clr_vec)) == '0));

    // R2: a newly set pending bit needs the interrupt function on that line
    a_r2_func_gate: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & ~$past(pend_q) & ~$past(en_vec)) == '0));

    // R8: lines 0..3 never hold pending state
    a_r8_no_direct_pend: assert property (@(posedge clk) disable iff (rst)
        pend_q[DIRECT_N-1:0] == '0);

endmodule

// File: rtl/xirq_trigger_unit.sv
module xirq_trigger_unit
    import xirq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NLINES-1:0]   ext_pin,
    input  logic                cfg_we,
    input  logic [AW-1:0]       cfg_addr,
    input  logic [DW-1:0]       cfg_wdata,
    output logic [DW-1:0]       cfg_rdata,
    output logic [DIRECT_N-1:0] direct_req,
    output logic                grp_lo_req,
    output logic                grp_hi_req,
    output logic                wake_req
);

    samp_t [NLINES-1:0]             smp;
    logic  [NLINES-1:0][MODE_W-1:0] mode;
    logic  [NLINES-1:0]             en_vec;
    logic  [NLINES-1:0]             hit;
    logic  [NLINES-1:0]             mask_q;
    logic  [NLINES-1:0]             pend_q;
    logic  [NLINES-1:0]             wmask_q;
    logic  [DIRECT_N-1:0]           direct_q;

    xirq_sync #(.LINES(NLINES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_raw (ext_pin),
        .smp     (smp)
    );

    xirq_detect #(.LINES(NLINES)) u_detect (
        .smp  (smp),
        .mode (mode),
        .en   (en_vec),
        .hit  (hit)
    );

    xirq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .hit     (hit),
        .rdata   (cfg_rdata),
        .mode    (mode),
        .en_vec  (en_vec),
        .mask_q  (mask_q),
        .pend_q  (pend_q),
        .wmask_q (wmask_q)
    );

    always_ff @(posedge clk) begin
        if (rst) direct_q <= '0;
        else     direct_q <= hit[DIRECT_N-1:0];
    end

    assign direct_req = direct_q;
    assign grp_lo_req = |(pend_q & ~mask_q & GRP_A_SET);
    assign grp_hi_req = |(pend_q & ~mask_q & GRP_B_SET);
    assign wake_req   = |(pend_q & ~wmask_q & WAKE_ALLOW);

    // R7: all four low-group mask bits set keeps the low-group request quiet
    a_r7_grp_lo_quiet: assert property (@(posedge clk) disable iff (rst)
        (&mask_q[GA_HI:GA_LO]) |-> !grp_lo_req);

    // R7: a shared request needs some pending line behind it
    a_r7_grp_needs_pend: assert property (@(posedge clk) disable iff (rst)
        (grp_lo_req || grp_hi_req) |-> (pend_q != '0));

    // R9: wake only from pending lines within the wake window
    a_r9_wake_source: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> ((pend_q & WAKE_ALLOW) != '0));

    // R8: a direct request needs the interrupt function one cycle earlier
    a_r8_direct_enabled: assert property (@(posedge clk) disable iff (rst)
        ((direct_req & ~$past(en_vec[DIRECT_N-1:0])) == '0));

endmodule

// File: tb/xirq_trigger_unit_bench.sv
module xirq_trigger_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] ext_pin = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [3:0]  direct_req;
    logic        grp_lo_req;
    logic        grp_hi_req;
    logic        wake_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    xirq_trigger_unit u_xirq_trigger_unit (
        .clk        (clk),
        .rst        (rst),
        .ext_pin    (ext_pin),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .direct_req (direct_req),
        .grp_lo_req (grp_lo_req),
        .grp_hi_req (grp_hi_req),
        .wake_req   (wake_req)
    );

    localparam logic [2:0] W_TRIG0 = 3'd0, W_TRIG1 = 3'd1, W_TRIG2 = 3'd2,
                           W_FLO = 3'd3, W_FHI = 3'd4, W_MASK = 3'd5,
                           W_PEND = 3'd6, W_WAKE = 3'd7;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic pin(input int k, input logic v);
        @(negedge clk);
        ext_pin[k] = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(W_TRIG0, d); chk("R1 trig0", d, 32'h0);
        rd(W_TRIG2, d); chk("R1 trig2", d, 32'h0);
        rd(W_FLO, d);   chk("R1 func lo", d, 32'h0);
        rd(W_MASK, d);  chk("R1 mask", d, 32'h00FFFFF0);
        rd(W_PEND, d);  chk("R1 pend", d, 32'h0);
        rd(W_WAKE, d);  chk("R1 wake mask", d, 32'h0000FFF0);
        chk("R1 outputs", {25'b0, direct_req, grp_lo_req, grp_hi_req, wake_req}, 32'h0);
    endtask

    task automatic t_func_gate();
        logic [31:0] d;
        wr(W_TRIG0, 32'h00400000);
        wr(W_MASK, 32'h00FFFFD0);
        pin(5, 1'b1);
        rd(W_PEND, d); chk("R2 disabled line no pend", d, 32'h0);
        chk("R2 disabled line no req", {31'b0, grp_lo_req}, 32'h0);
        pin(5, 1'b0);
        wr(W_FLO, 32'h00000800);
        pin(5, 1'b1);
        rd(W_PEND, d); chk("R2 R3 enabled rising sets pend", d, 32'h00000020);
        chk("R7 low group request", {31'b0, grp_lo_req}, 32'h1);
        wr(W_PEND, 32'h00000020);
        rd(W_PEND, d); chk("R6 clear line5", d, 32'h0);
        chk("R7 low group drops", {31'b0, grp_lo_req}, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(W_MASK, 32'h00FFFFF0);
        pin(5, 1'b0);
        pin(5, 1'b1);
        rd(W_PEND, d); chk("R7 masked still latches", d, 32'h00000020);
        chk("R7 masked no request", {31'b0, grp_lo_req}, 32'h0);
        wr(W_MASK, 32'h00FFFFD0);
        chk("R7 unmask raises", {31'b0, grp_lo_req}, 32'h1);
        chk("R7 high group idle", {31'b0, grp_hi_req}, 32'h0);
        wr(W_MASK, 32'h00FFFFF0);
        chk("R7 all four masked", {31'b0, grp_lo_req}, 32'h0);
        wr(W_PEND, 32'h00000020);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(W_TRIG1, 32'h00000020);
        wr(W_FLO, 32'h00080800);
        wr(W_MASK, 32'h00FFFDF0);
        pin(9, 1'b1);
        rd(W_PEND, d); chk("R4 falling ignores rise", d, 32'h0);
        pin(9, 1'b0);
        rd(W_PEND, d); chk("R4 falling sets", d, 32'h00000200);
        chk("R7 high group request", {31'b0, grp_hi_req}, 32'h1);
        wr(W_PEND, 32'h0);
        rd(W_PEND, d); chk("R6 write zero keeps", d, 32'h00000200);
        wr(W_PEND, 32'h00000200);
        rd(W_PEND, d); chk("R6 write one clears", d, 32'h0);
        chk("R7 high group drops", {31'b0, grp_hi_req}, 32'h0);
        wr(W_TRIG1, 32'h00000060);
        pin(9, 1'b1);
        rd(W_PEND, d); chk("R4 both mode rise", d, 32'h00000200);
        // fall event lands on the clearing edge
        @(negedge clk); ext_pin[9] = 1'b0;
        @(negedge clk);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = W_PEND; cfg_wdata = 32'h00000200;
        @(negedge clk); cfg_we = 1'b0;
        rd(W_PEND, d); chk("R6 edge kept over clear", d, 32'h00000200);
        wr(W_PEND, 32'h00000200);
        wr(W_TRIG1, 32'h00000040);
        pin(9, 1'b1);
        rd(W_PEND, d); chk("R4 rising sets", d, 32'h00000200);
        wr(W_PEND, 32'h00000200);
        pin(9, 1'b0);
        rd(W_PEND, d); chk("R4 rising ignores fall", d, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(W_TRIG2, 32'h00000010);
        wr(W_FHI, 32'h00000008);
        wr(W_MASK, 32'h00FDFFF0);
        pin(17, 1'b1);
        rd(W_PEND, d); chk("R3 high level sets", d, 32'h00020000);
        chk("R7 high group from line17", {31'b0, grp_hi_req}, 32'h1);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = W_PEND; cfg_wdata = 32'h00020000;
        @(posedge clk);
        #1 d = cfg_rdata; chk("R5 one cycle cleared", d, 32'h0);
        @(negedge clk); cfg_we = 1'b0;
        @(negedge clk);
        rd(W_PEND, d); chk("R5 level re-sets", d, 32'h00020000);
        pin(17, 1'b0);
        wr(W_PEND, 32'h00020000);
        @(negedge clk);
        rd(W_PEND, d); chk("R5 clear sticks without level", d, 32'h0);
        wr(W_TRIG2, 32'h00000000);
        repeat (2) @(negedge clk);
        rd(W_PEND, d); chk("R3 low level sets", d, 32'h00020000);
        wr(W_TRIG2, 32'h00000010);
        wr(W_PEND, 32'h00020000);
        @(negedge clk);
        rd(W_PEND, d); chk("R5 high mode low pin clear", d, 32'h0);
        rd(W_TRIG2, d); chk("R10 trig readback", d, 32'h00000010);
        wr(W_MASK, 32'h00FFFFF0);
    endtask

    task automatic t_direct();
        logic [31:0] d;
        wr(W_TRIG0, 32'h00000400);
        wr(W_FLO, 32'h00000020);
        @(negedge clk); ext_pin[2] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 rising pulse", {28'b0, direct_req}, 32'h4);
        @(negedge clk);
        chk("R8 pulse one cycle", {28'b0, direct_req}, 32'h0);
        rd(W_PEND, d); chk("R8 no pend for direct line", d, 32'h0);
        wr(W_TRIG0, 32'h00000401);
        wr(W_FLO, 32'h00000022);
        pin(0, 1'b1);
        chk("R8 level request", {28'b0, direct_req}, 32'h1);
        repeat (5) @(negedge clk);
        chk("R8 level held", {28'b0, direct_req}, 32'h1);
        pin(0, 1'b0);
        chk("R8 level released", {28'b0, direct_req}, 32'h0);
    endtask

    task automatic t_wake();
        logic [31:0] d;
        wr(W_TRIG1, 32'h00000040);
        wr(W_FLO, 32'h00080000);
        wr(W_MASK, 32'h00FFFFF0);
        pin(9, 1'b1);
        rd(W_PEND, d); chk("R9 line9 pending", d, 32'h00000200);
        chk("R9 wake masked", {31'b0, wake_req}, 32'h0);
        wr(W_WAKE, 32'h0000FDF0);
        chk("R9 wake enabled", {31'b0, wake_req}, 32'h1);
        rd(W_WAKE, d); chk("R10 wake readback", d, 32'h0000FDF0);
        wr(W_WAKE, 32'h0000FFF0);
        chk("R9 wake masked again", {31'b0, wake_req}, 32'h0);
        wr(W_PEND, 32'h00000200);
        wr(W_TRIG2, 32'h00000040);
        wr(W_FHI, 32'h00000008);
        wr(W_WAKE, 32'h00000000);
        pin(17, 1'b1);
        rd(W_PEND, d); chk("R9 line17 pending", d, 32'h00020000);
        chk("R9 no wake above 15", {31'b0, wake_req}, 32'h0);
        wr(W_WAKE, 32'hFFFFFFFF);
        rd(W_WAKE, d); chk("R10 wake unimplemented bits", d, 32'h0000FFF0);
        wr(W_MASK, 32'hFFFFFFFF);
        rd(W_MASK, d); chk("R10 mask unimplemented bits", d, 32'h00FFFFF0);
        wr(W_FHI, 32'hFFFFFFFF);
        rd(W_FHI, d); chk("R10 func hi width", d, 32'h0000FFFF);
        wr(W_TRIG0, 32'hFFFFFFFF);
        rd(W_TRIG0, d); chk("R10 trig slot top bit", d, 32'h77777777);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_func_gate();
        t_mask();
        t_edge();
        t_level();
        t_direct();
        t_wake();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule